// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Condition Flags

This block shifts or rotates one operand by a count and produces the new condition flags. It handles eight operations: arithmetic, logical and rotate moves in each direction, plus two rotates that pass through the extend bit. Each operation works on the low 8, 16 or 32 bits of a 32-bit operand. Any bits above the selected size come back unchanged. The block also returns new extend (X), negative (N), zero (Z), overflow (V) and carry (C) flags.

Operands arrive on a valid/ready stream. The result leaves on a registered valid/ready stream one cycle after the operand is accepted. The input is ready whenever the output register is empty or being drained. When `out_ready` is low and a result is waiting, `in_ready` drops. The waiting result and its flags then hold steady until `out_ready` rises, so the producer must keep its operand on the input until it is taken. A single-bit mode input selects the memory-destination form. In that form the operand is always a word, the count is always one, and the size and count inputs are ignored.

Top module: `srf_unit`

## Requirements
- R1: An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and all flags hold. After reset, `out_valid` is low and `in_ready` is high.
- R2: `in_size` selects the width: 0 is byte (bits 7:0), 1 is word (bits 15:0), and 2 or 3 is long (bits 31:0). `out_data` bits above the selected width equal the same bits of `in_data`.
- R3: `in_op` 0 is the arithmetic left shift and 2 is the logical left shift. Both fill with zeros from bit 0. C and X take the last bit moved out past the top bit. For counts above the width the result is zero and C = X = 0.
- R4: `in_op` 1 is the arithmetic right shift. It refills the top bit with its own value. C and X take the last bit moved out of bit 0. For counts of the width or more, every result bit and C and X equal the original sign bit.
- R5: `in_op` 3 is the logical right shift. It fills with zeros from the top. C and X take the last bit moved out of bit 0, or 0 when the count is above the width.
- R6: `in_op` 4 rotates left and 5 rotates right, within the selected width. C equals the last bit carried around. X is left equal to `in_x`.
- R7: `in_op` 6 rotates left and 7 rotates right through a ring of width+1 bits, with `in_x` as the extra bit. X and C both equal the extend bit after the move.
- R8: N is the top bit of the sized result. Z is 1 exactly when the sized result is zero.
- R9: V is 0 for every operation except the arithmetic left shift. For that shift, V is 1 when the top bit takes a value different from its starting value at any step.
- R10: With a count of zero the sized result is unchanged and X keeps `in_x`. C is 0, except for operations 6 and 7, where C equals `in_x`.
- R11: With `in_mem` high the operation runs at word size with a count of one, whatever `in_size` and `in_count` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken |
| in_op | input | 3 | Operation code (see R3 to R7) |
| in_size | input | 2 | Operand size select |
| in_mem | input | 1 | Memory-destination form: word, count one |
| in_count | input | 6 | Shift or rotate count, 0 to 63 |
| in_data | input | 32 | Operand |
| in_x | input | 1 | Incoming extend flag |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result, upper bits preserved |
| out_x | output | 1 | New extend flag |
| out_n | output | 1 | New negative flag |
| out_z | output | 1 | New zero flag |
| out_v | output | 1 | New overflow flag |
| out_c | output | 1 | New carry flag |

## Verification
Two cases are hard to reach from the ports. The first is an arithmetic left shift whose top bit changes only on a late step. The second is a rotate through extend whose count wraps the width+1 ring one or more times, for example 63 on a 9-bit ring. A targeted test is unlikely to hit either one. The stimulus therefore sweeps every count from 0 to 63 for every operation, size and incoming X, over operand patterns with sign changes placed at different depths. A step-by-step bench model checks each result. Stall holding is reached by lowering `out_ready` with a result waiting and offering a second operand that must not be taken.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int SRF_DATA_W = 32;
  localparam int SRF_CNT_W  = 6;
  localparam int SRF_IDX_W  = $clog2(SRF_DATA_W);
  localparam int SRF_AMT_W  = SRF_IDX_W + 3;

  typedef logic [SRF_DATA_W-1:0] data_t;
  typedef logic [SRF_DATA_W:0]   ring_t;
  typedef logic [SRF_AMT_W-1:0]  amt_t;

  typedef enum logic [2:0] {
    OP_ASL  = 3'd0,
    OP_ASR  = 3'd1,
    OP_LSL  = 3'd2,
    OP_LSR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_ROR  = 3'd5,
    OP_ROXL = 3'd6,
    OP_ROXR = 3'd7
  } srf_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } srf_size_e;

  typedef struct packed {
    data_t data;
    logic  x;
    logic  n;
    logic  z;
    logic  v;
    logic  c;
  } srf_res_t;

  function automatic amt_t size_width(srf_size_e s);
    case (s)
      SZ_BYTE: return amt_t'(8);
      SZ_WORD: return amt_t'(16);
      default: return amt_t'(SRF_DATA_W);
    endcase
  endfunction
endpackage

// File: rtl/srf_shift_path.sv
module srf_shift_path
  import srf_pkg::*;
(
  input  srf_op_e op,
  input  data_t   a,
  input  data_t   full,
  input  amt_t    w,
  input  amt_t    cnt,
  output data_t   res,
  output logic    c,
  output logic    v
);
  localparam amt_t ONE = amt_t'(1);

  logic                 msb;
  logic                 nz;
  logic                 in_rng;
  logic [SRF_IDX_W-1:0] idx_l;
  logic [SRF_IDX_W-1:0] idx_r;
  data_t                sa;
  data_t                sign_hi;
  data_t                vmask;
  data_t                vtop;

  always_comb begin
    msb     = a[SRF_IDX_W'(w - ONE)];
    nz      = (cnt != '0);
    in_rng  = (cnt <= w);
    idx_l   = SRF_IDX_W'(w - cnt);
    idx_r   = SRF_IDX_W'(cnt - ONE);
    sa      = a | (msb ? ~full : '0);
    sign_hi = msb ? ~({SRF_DATA_W{1'b1}} >> cnt) : '0;
    // top count+1 bits of the operand: all must agree for no sign change
    vmask   = full & ~(full >> (cnt + ONE));
    vtop    = a & vmask;
    res     = a;
    c       = 1'b0;
    v       = 1'b0;
    case (op)
      OP_ASL, OP_LSL: begin
        res = (a << cnt) & full;
        c   = nz && in_rng && a[idx_l];
        if (op == OP_ASL) begin
          if (cnt < w) v = (vtop != '0) && (vtop != vmask);
          else         v = (a != '0);
        end
      end
      OP_ASR: begin
        res = ((sa >> cnt) | sign_hi) & full;
        c   = nz && (in_rng ? a[idx_r] : msb);
      end
      OP_LSR: begin
        res = (a >> cnt) & full;
        c   = nz && in_rng && a[idx_r];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/srf_rotate_path.sv
module srf_rotate_path
  import srf_pkg::*;
(
  input  srf_op_e op,
  input  data_t   a,
  input  data_t   full,
  input  amt_t    w,
  input  amt_t    cnt,
  input  logic    x_in,
  output data_t   res,
  output logic    c,
  output logic    x_out
);
  localparam amt_t ONE = amt_t'(1);
  // smallest ring is a byte plus the extend bit
  localparam int MIN_RING = 9;
  localparam int SUB_N    = (1 << SRF_CNT_W) / MIN_RING + 1;

  logic  nz;
  amt_t  kr;
  amt_t  kx;
  amt_t  ring_len;
  ring_t ring;
  ring_t ring_mask;
  ring_t rr;
  data_t rot;

  always_comb begin
    nz        = (cnt != '0);
    kr        = cnt & (w - ONE);
    ring_len  = w + ONE;
    kx        = cnt;
    for (int i = 0; i < SUB_N; i++) begin
      if (kx >= ring_len) kx = kx - ring_len;
    end
    ring_mask = (ring_t'(1) << ring_len) - ring_t'(1);
    ring      = ring_t'(a) | (ring_t'(x_in) << w);
    rot       = a;
    rr        = ring;
    res       = a;
    c         = 1'b0;
    x_out     = x_in;
    case (op)
      OP_ROL: begin
        rot = ((a << kr) | (a >> (w - kr))) & full;
        res = rot;
        c   = nz && rot[0];
      end
      OP_ROR: begin
        rot = ((a >> kr) | (a << (w - kr))) & full;
        res = rot;
        c   = nz && rot[SRF_IDX_W'(w - ONE)];
      end
      OP_ROXL, OP_ROXR: begin
        if (op == OP_ROXL)
          rr = ((ring << kx) | (ring >> (ring_len - kx))) & ring_mask;
        else
          rr = ((ring >> kx) | (ring << (ring_len - kx))) & ring_mask;
        res   = rr[SRF_DATA_W-1:0] & full;
        x_out = rr[(SRF_IDX_W+1)'(w)];
        c     = x_out;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/srf_flag_merge.sv
module srf_flag_merge
  import srf_pkg::*;
(
  input  srf_op_e  op,
  input  data_t    orig,
  input  data_t    full,
  input  amt_t     w,
  input  amt_t     cnt,
  input  logic     x_in,
  input  data_t    sh_res,
  input  logic     sh_c,
  input  logic     sh_v,
  input  data_t    ro_res,
  input  logic     ro_c,
  input  logic     ro_x,
  output srf_res_t res
);
  logic  is_shift;
  data_t sized;

  always_comb begin
    is_shift = op inside {OP_ASL, OP_ASR, OP_LSL, OP_LSR};
    sized    = (is_shift ? sh_res : ro_res) & full;
    res.data = (orig & ~full) | sized;
    res.n    = sized[SRF_IDX_W'(w - amt_t'(1))];
    res.z    = (sized == '0);
    res.v    = is_shift && sh_v;
    res.c    = is_shift ? sh_c : ro_c;
    if (is_shift) res.x = (cnt != '0) ? sh_c : x_in;
    else          res.x = ro_x;
  end
endmodule

// File: rtl/srf_unit.sv
module srf_unit
  import srf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2:0]            in_op,
  input  logic [1:0]            in_size,
  input  logic                  in_mem,
  input  logic [SRF_CNT_W-1:0]  in_count,
  input  logic [SRF_DATA_W-1:0] in_data,
  input  logic                  in_x,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SRF_DATA_W-1:0] out_data,
  output logic                  out_x,
  output logic                  out_n,
  output logic                  out_z,
  output logic                  out_v,
  output logic                  out_c
);
  srf_op_e   op;
  srf_size_e size_eff;
  amt_t      w;
  amt_t      cnt_eff;
  data_t     full;
  data_t     a;
  data_t     sh_res;
  data_t     ro_res;
  logic      sh_c, sh_v, ro_c, ro_x;
  logic      accept;
  logic      vld_q;
  srf_res_t  nxt;
  srf_res_t  q;

  always_comb begin
    op       = srf_op_e'(in_op);
    size_eff = in_mem ? SZ_WORD : srf_size_e'(in_size);
    cnt_eff  = in_mem ? amt_t'(1) : amt_t'(in_count);
    w        = size_width(size_eff);
    full     = (data_t'(1) << w) - data_t'(1);
    a        = in_data & full;
  end

  srf_shift_path u_shift (
    .op(op), .a(a), .full(full), .w(w), .cnt(cnt_eff),
    .res(sh_res), .c(sh_c), .v(sh_v)
  );

  srf_rotate_path u_rot (
    .op(op), .a(a), .full(full), .w(w), .cnt(cnt_eff), .x_in(in_x),
    .res(ro_res), .c(ro_c), .x_out(ro_x)
  );

  srf_flag_merge u_merge (
    .op(op), .orig(in_data), .full(full), .w(w), .cnt(cnt_eff), .x_in(in_x),
    .sh_res(sh_res), .sh_c(sh_c), .sh_v(sh_v),
    .ro_res(ro_res), .ro_c(ro_c), .ro_x(ro_x),
    .res(nxt)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      q     <= nxt;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = q.data;
  assign out_x     = q.x;
  assign out_n     = q.n;
  assign out_z     = q.z;
  assign out_v     = q.v;
  assign out_c     = q.c;

  p_accept_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_c)
                                   && $stable(out_x) && $stable(out_v)));

  p_upper_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_mem && in_size == 2'd0)
      |=> out_data[SRF_DATA_W-1:8] == $past(in_data[SRF_DATA_W-1:8]));

  p_rot_x_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == 3'd4 || in_op == 3'd5)) |=> out_x == $past(in_x));

  p_ext_cx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == 3'd6 || in_op == 3'd7)) |=> out_c == out_x);

  p_zero_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_data & full) == '0 && in_op[2:1] != 2'b11) |=> (out_z && !out_n));

  p_v_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op != 3'd0) |=> !out_v);

  p_zero_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_mem && in_count == '0 && in_op[2:1] != 2'b11)
      |=> (!out_c && out_x == $past(in_x)));
endmodule

// File: tb/sim_srf_unit.sv
module sim_srf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic        in_mem = 1'b0;
  logic [5:0]  in_count = '0;
  logic [31:0] in_data = '0;
  logic        in_x = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_x, out_n, out_z, out_v, out_c;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  srf_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_mem(in_mem), .in_count(in_count),
    .in_data(in_data), .in_x(in_x), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_x(out_x), .out_n(out_n), .out_z(out_z),
    .out_v(out_v), .out_c(out_c)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // step-by-step model: one bit per step
  task automatic ref_model(input int op, input int w, input int cnt, input logic [31:0] din,
                           input logic xin, output logic [31:0] dout, output logic x,
                           output logic n, output logic z, output logic v, output logic c);
    logic [31:0] mask, d;
    logic hi, lo, m0;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    d = din & mask;
    x = xin; c = 1'b0; v = 1'b0;
    m0 = d[w-1];
    for (int i = 0; i < cnt; i++) begin
      hi = d[w-1];
      lo = d[0];
      case (op)
        0: begin d = (d << 1) & mask; c = hi; x = hi; if (d[w-1] != m0) v = 1'b1; end
        1: begin d = (d >> 1) | (hi ? (32'h1 << (w-1)) : 32'h0); c = lo; x = lo; end
        2: begin d = (d << 1) & mask; c = hi; x = hi; end
        3: begin d = d >> 1; c = lo; x = lo; end
        4: begin d = ((d << 1) | 32'(hi)) & mask; c = hi; end
        5: begin d = (d >> 1) | (32'(lo) << (w-1)); c = lo; end
        6: begin d = ((d << 1) | 32'(x)) & mask; x = hi; c = hi; end
        default: begin d = (d >> 1) | (32'(x) << (w-1)); x = lo; c = lo; end
      endcase
    end
    if (cnt == 0) c = (op >= 6) ? xin : 1'b0;
    dout = (din & ~mask) | d;
    n = d[w-1];
    z = (d == 32'h0);
  endtask

  function automatic string op_tag(input int op, input int cnt);
    if (cnt == 0) return "R10";
    case (op)
      0, 2: return "R3";
      1: return "R4";
      3: return "R5";
      4, 5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(input int op, input int sz, input bit mem, input int cnt,
                       input logic [31:0] d, input logic x);
    in_valid = 1'b1;
    in_op = 3'(op);
    in_size = 2'(sz);
    in_mem = mem;
    in_count = 6'(cnt);
    in_data = d;
    in_x = x;
  endtask

  task automatic check_all(input string tag, input string dtag, input logic [31:0] ed,
                           input logic ex, input logic en, input logic ez,
                           input logic ev, input logic ec);
    chk(dtag, out_data, ed);
    chk({tag, " C/X"}, {30'b0, out_c, out_x}, {30'b0, ec, ex});
    chk("R8 N/Z", {30'b0, out_n, out_z}, {30'b0, en, ez});
    chk("R9 V", {31'b0, out_v}, {31'b0, ev});
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    logic [31:0] ed;
    logic ex, en, ez, ev, ec;
    int widths [3];
    pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
             32'hA5C3_9E81, 32'h8000_0080, 32'h4000_7F01};
    widths = '{8, 16, 32};

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset valid", {31'b0, out_valid}, 32'h0);
    chk("R1 reset ready", {31'b0, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // full sweep: every op, size, count, extend value and pattern
    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 3; sz++)
        for (int p = 0; p < 6; p++)
          for (int xi = 0; xi < 2; xi++)
            for (int cnt = 0; cnt < 64; cnt++) begin
              drive(op, sz, 1'b0, cnt, pats[p], xi[0]);
              ref_model(op, widths[sz], cnt, pats[p], xi[0], ed, ex, en, ez, ev, ec);
              @(negedge clk);
              check_all(op_tag(op, cnt), (sz < 2) ? "R2 data" : {op_tag(op, cnt), " data"},
                        ed, ex, en, ez, ev, ec);
            end

    // R11: memory form ignores size and count
    for (int op = 0; op < 8; op++)
      for (int p = 0; p < 6; p++) begin
        drive(op, 0, 1'b1, 37, pats[p], p[0]);
        ref_model(op, 16, 1, pats[p], p[0], ed, ex, en, ez, ev, ec);
        @(negedge clk);
        check_all("R11", "R11 data", ed, ex, en, ez, ev, ec);
      end

    // R1: back-pressure
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    drive(2, 1, 1'b0, 4, 32'h1234_8765, 1'b0);
    ref_model(2, 16, 4, 32'h1234_8765, 1'b0, ed, ex, en, ez, ev, ec);
    @(negedge clk);
    chk("R1 valid after accept", {31'b0, out_valid}, 32'h1);
    chk("R1 ready low when stalled", {31'b0, in_ready}, 32'h0);
    drive(3, 2, 1'b0, 8, 32'hCAFE_F00D, 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 hold data", out_data, ed);
    chk("R1 hold flags", {27'b0, out_x, out_n, out_z, out_v, out_c},
        {27'b0, ex, en, ez, ev, ec});
    out_ready = 1'b1;
    ref_model(3, 32, 8, 32'hCAFE_F00D, 1'b1, ed, ex, en, ez, ev, ec);
    @(negedge clk);
    chk("R1 second taken", out_data, ed);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 drained", {31'b0, out_valid}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule